// File: doc/BRIEF.md
# Load/Store Address Former and Load Data Extender

This unit sits between a core's decode stage and a simple single-port data memory. For each single-register load or store it works out the effective byte address from a base value and an offset. It also decides which byte lanes of the 32-bit bus the access touches. A store's data is copied onto those lanes. A load's raw read word has the addressed byte or halfword taken out of it and widened to a full word, with either zero or sign extension.

Four addressing forms are supported. In the first, a base register is added to an unscaled index register. In the second, a base register is added to a short immediate that is scaled by the access size. In the third, a longer immediate is scaled by four and added to the stack pointer. In the fourth, the same longer immediate is added to the program counter plus four, rounded down to a word boundary. Misaligned halfword and word accesses are never split. Instead they raise a fault flag, and no write and no load result can happen for them.

Address, fault, strobe and store data are combinational from the request. The formatted load word is captured in a register, which is updated on the clock edge at which the read data is presented.

Top module: `ldst_agu`

## Requirements
- R1: With `addrMode` = 0 (register index), `busAddr` = `baseVal` + `indexVal`, full 32-bit and unscaled, for every access size.
- R2: With `addrMode` = 1 (short immediate), `busAddr` = `baseVal` + (zero-extended `indexVal[4:0]` shifted left by `accSize`). The encoding is byte=0 with shift 0, halfword=1 with shift 1, and word=2 with shift 2. The higher bits of `indexVal` have no effect.
- R3: With `addrMode` = 2 (stack relative), `busAddr` = `spVal` + (zero-extended `indexVal[7:0]` shifted left by 2).
- R4: With `addrMode` = 3 (PC relative), `busAddr` = ((`pcVal` + 4) with bits [1:0] cleared) + (zero-extended `indexVal[7:0]` shifted left by 2).
- R5: `alignFault` is high only while `reqValid` is high. It is set for a halfword access whose `busAddr[0]` is 1, and for a word access (`accSize` 2, or the reserved code 3, which is treated as word) whose `busAddr[1:0]` is not zero. Byte accesses never fault.
- R6: A faulting access drives `wrStrobe` to 0. A faulting load produces no `loadValid` pulse and leaves `loadResult` unchanged.
- R7: `wrStrobe` is nonzero only for a valid, aligned store, and memory is little-endian. A byte access sets bit `busAddr[1:0]`. A halfword access sets 4'b0011 when `busAddr[1]` is 0 and 4'b1100 when it is 1. A word access sets 4'b1111.
- R8: `busWrData` repeats `storeData[7:0]` on all four lanes for byte accesses and `storeData[15:0]` on both halves for halfword accesses. For word accesses it equals `storeData`.
- R9: An unsigned load returns the byte in lane `busAddr[1:0]`, or the halfword in lanes {`busAddr[1]`,0} and {`busAddr[1]`,1}, zero-extended to 32 bits.
- R10: With `isSigned` = 1, byte and halfword loads copy bit 7 or bit 15 of the extracted value into all higher bits. A word load ignores `isSigned`.
- R11: In a cycle with `reqValid` = 1, `isStore` = 0, no fault and `rdValid` = 1, the formatted value appears on `loadResult` after the next rising clock edge, and `loadValid` is high for exactly that one cycle. Otherwise `loadValid` is 0 and `loadResult` holds its value. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access is presented this cycle |
| isStore | input | 1 | 1 = store, 0 = load |
| accSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| isSigned | input | 1 | Sign-extend byte/halfword loads |
| addrMode | input | 2 | 0 register index, 1 short immediate, 2 stack relative, 3 PC relative |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value or immediate in the low bits |
| spVal | input | 32 | Stack pointer value |
| pcVal | input | 32 | Program counter of the access instruction |
| storeData | input | 32 | Register value to store |
| rdValid | input | 1 | `rdData` holds the read word for the current access |
| rdData | input | 32 | Raw read word from memory |
| busAddr | output | 32 | Effective byte address |
| wrStrobe | output | 4 | Per-byte write enables |
| busWrData | output | 32 | Lane-replicated store data |
| alignFault | output | 1 | Misaligned access |
| loadResult | output | 32 | Registered, extended load value |
| loadValid | output | 1 | One-cycle pulse marking a new `loadResult` |

## Verification
The address, fault flag, write strobe and replicated store data are due in the same cycle as the request. The bench drives each request on a falling edge and checks these outputs one time unit later, before the next rising edge. The load result and its valid pulse pass through one register, so they are checked on the falling edge that follows the capturing rising edge. A further check one cycle later, with the read data withdrawn, confirms that the pulse has dropped and the value is held.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
  localparam int XLEN  = 32;
  localparam int LANES = XLEN / 8;
  localparam int LSB_W = $clog2(LANES);

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} accSize_e;
  typedef enum logic [1:0] {AM_REGIDX = 2'd0, AM_IMM5 = 2'd1, AM_SPREL = 2'd2, AM_PCREL = 2'd3} addrMode_e;
  typedef enum logic [1:0] {BS_BASE = 2'd0, BS_SP = 2'd1, BS_PCALIGN = 2'd2} baseSel_e;
  typedef enum logic [1:0] {OS_REG = 2'd0, OS_SHORT = 2'd1, OS_LONG = 2'd2} offSel_e;

  // strobes steering the address adder
  typedef struct packed {
    baseSel_e   baseSel;
    offSel_e    offSel;
    logic [1:0] offShift;
  } addrCtrl_t;

  // strobes steering lanes and load capture
  typedef struct packed {
    logic [LANES-1:0] laneMask;
    logic             wrEn;
    logic             ldCapture;
    logic             signExt;
    accSize_e         fmtSize;
  } accCtrl_t;
endpackage

// File: rtl/ldst_agu_ctrl.sv
module ldst_agu_ctrl
  import ldst_agu_pkg::*;
(
  input  logic             reqValid,
  input  logic             isStore,
  input  logic             isSigned,
  input  logic [1:0]       accSize,
  input  logic [1:0]       addrMode,
  input  logic [LSB_W-1:0] addrLow,
  output addrCtrl_t        aCtl,
  output accCtrl_t         xCtl,
  output logic             fault
);
  accSize_e  sizeE;
  addrMode_e modeE;
  logic      misaligned;

  assign sizeE = accSize_e'(accSize);
  assign modeE = addrMode_e'(addrMode);

  // address steering depends only on mode and size
  always_comb begin
    aCtl = '{baseSel: BS_BASE, offSel: OS_REG, offShift: 2'd0};
    unique case (modeE)
      AM_REGIDX: aCtl = '{baseSel: BS_BASE, offSel: OS_REG, offShift: 2'd0};
      AM_IMM5: begin
        aCtl.baseSel = BS_BASE;
        aCtl.offSel  = OS_SHORT;
        unique case (sizeE)
          SZ_BYTE: aCtl.offShift = 2'd0;
          SZ_HALF: aCtl.offShift = 2'd1;
          default: aCtl.offShift = 2'd2;
        endcase
      end
      AM_SPREL:  aCtl = '{baseSel: BS_SP, offSel: OS_LONG, offShift: 2'd2};
      AM_PCREL:  aCtl = '{baseSel: BS_PCALIGN, offSel: OS_LONG, offShift: 2'd2};
      default:   aCtl = '{baseSel: BS_BASE, offSel: OS_REG, offShift: 2'd0};
    endcase
  end

  // alignment and lane selection depend on the formed address
  always_comb begin
    unique case (sizeE)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addrLow[0];
      default: misaligned = |addrLow;
    endcase
  end

  assign fault = reqValid & misaligned;

  always_comb begin
    xCtl.laneMask  = '0;
    unique case (sizeE)
      SZ_BYTE: xCtl.laneMask[addrLow] = 1'b1;
      SZ_HALF: xCtl.laneMask = addrLow[1] ? 4'b1100 : 4'b0011;
      default: xCtl.laneMask = '1;
    endcase
    xCtl.wrEn      = reqValid & isStore & ~fault;
    xCtl.ldCapture = reqValid & ~isStore & ~fault;
    xCtl.signExt   = isSigned;
    xCtl.fmtSize   = sizeE;
  end

  // R7
  always_comb begin
    if (xCtl.wrEn) wr_lane_count_chk: assert ($countones(xCtl.laneMask) ==
        ((sizeE == SZ_BYTE) ? 1 : (sizeE == SZ_HALF) ? 2 : 4));
  end
endmodule

// File: rtl/ldst_agu_dp.sv
module ldst_agu_dp
  import ldst_agu_pkg::*;
#(
  parameter int IMM_SHORT_W = 5,
  parameter int IMM_LONG_W  = 8,
  parameter int PC_AHEAD    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  addrCtrl_t        aCtl,
  input  accCtrl_t         xCtl,
  input  logic [XLEN-1:0]  baseVal,
  input  logic [XLEN-1:0]  indexVal,
  input  logic [XLEN-1:0]  spVal,
  input  logic [XLEN-1:0]  pcVal,
  input  logic [XLEN-1:0]  storeData,
  input  logic             rdValid,
  input  logic [XLEN-1:0]  rdData,
  output logic [XLEN-1:0]  busAddr,
  output logic [LANES-1:0] wrStrobe,
  output logic [XLEN-1:0]  busWrData,
  output logic [XLEN-1:0]  loadResult,
  output logic             loadValid
);
  localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(LANES - 1);

  logic [XLEN-1:0] pcAligned, baseMux, offRaw, fmtWord;
  logic [7:0]      byteSel;
  logic [15:0]     halfSel;
  logic            capture;

  assign pcAligned = (pcVal + XLEN'(PC_AHEAD)) & WORD_MASK;

  always_comb begin
    unique case (aCtl.baseSel)
      BS_SP:      baseMux = spVal;
      BS_PCALIGN: baseMux = pcAligned;
      default:    baseMux = baseVal;
    endcase
    unique case (aCtl.offSel)
      OS_SHORT: offRaw = XLEN'(indexVal[IMM_SHORT_W-1:0]);
      OS_LONG:  offRaw = XLEN'(indexVal[IMM_LONG_W-1:0]);
      default:  offRaw = indexVal;
    endcase
  end

  assign busAddr  = baseMux + (offRaw << aCtl.offShift);
  assign wrStrobe = xCtl.wrEn ? xCtl.laneMask : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign busWrData[i*8 +: 8] =
      (xCtl.fmtSize == SZ_BYTE) ? storeData[7:0] :
      (xCtl.fmtSize == SZ_HALF) ? storeData[(i % 2)*8 +: 8] :
                                  storeData[i*8 +: 8];
  end

  always_comb begin
    byteSel = rdData[{busAddr[LSB_W-1:0], 3'b000} +: 8];
    halfSel = rdData[{busAddr[LSB_W-1], 4'b0000} +: 16];
    unique case (xCtl.fmtSize)
      SZ_BYTE: fmtWord = {{(XLEN-8){xCtl.signExt & byteSel[7]}}, byteSel};
      SZ_HALF: fmtWord = {{(XLEN-16){xCtl.signExt & halfSel[15]}}, halfSel};
      default: fmtWord = rdData;
    endcase
  end

  assign capture = xCtl.ldCapture & rdValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadValid  <= 1'b0;
      loadResult <= '0;
    end else begin
      loadValid <= capture;
      if (capture) loadResult <= fmtWord;
    end
  end

  // R11
  load_pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> !loadValid && $stable(loadResult));

  // R11
  load_pulse_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> loadValid);
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_agu_pkg::*;
#(
  parameter int IMM_SHORT_W = 5,
  parameter int IMM_LONG_W  = 8,
  parameter int PC_AHEAD    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        isStore,
  input  logic [1:0]  accSize,
  input  logic        isSigned,
  input  logic [1:0]  addrMode,
  input  logic [31:0] baseVal,
  input  logic [31:0] indexVal,
  input  logic [31:0] spVal,
  input  logic [31:0] pcVal,
  input  logic [31:0] storeData,
  input  logic        rdValid,
  input  logic [31:0] rdData,
  output logic [31:0] busAddr,
  output logic [3:0]  wrStrobe,
  output logic [31:0] busWrData,
  output logic        alignFault,
  output logic [31:0] loadResult,
  output logic        loadValid
);
  addrCtrl_t aCtl;
  accCtrl_t  xCtl;

  ldst_agu_ctrl u_ctrl (
    .reqValid (reqValid),
    .isStore  (isStore),
    .isSigned (isSigned),
    .accSize  (accSize),
    .addrMode (addrMode),
    .addrLow  (busAddr[LSB_W-1:0]),
    .aCtl     (aCtl),
    .xCtl     (xCtl),
    .fault    (alignFault)
  );

  ldst_agu_dp #(
    .IMM_SHORT_W (IMM_SHORT_W),
    .IMM_LONG_W  (IMM_LONG_W),
    .PC_AHEAD    (PC_AHEAD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .aCtl       (aCtl),
    .xCtl       (xCtl),
    .baseVal    (baseVal),
    .indexVal   (indexVal),
    .spVal      (spVal),
    .pcVal      (pcVal),
    .storeData  (storeData),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .busAddr    (busAddr),
    .wrStrobe   (wrStrobe),
    .busWrData  (busWrData),
    .loadResult (loadResult),
    .loadValid  (loadValid)
  );

  // R6
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> wrStrobe == 4'b0000);

  // R6
  fault_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |=> !loadValid);

  // R4
  pc_word_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && addrMode == 2'd3 |-> busAddr[1:0] == 2'b00);

  // R5
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && accSize[1] && !alignFault |-> busAddr[1:0] == 2'b00);

  // R5
  fault_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> reqValid);
endmodule

// File: tb/sim_ldst_agu.sv
module sim_ldst_agu;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, isStore = 1'b0, isSigned = 1'b0, rdValid = 1'b0;
  logic [1:0]  accSize = 2'd0, addrMode = 2'd0;
  logic [31:0] baseVal = 32'h1000, indexVal = '0, spVal = '0, pcVal = '0;
  logic [31:0] storeData = '0, rdData = '0;
  logic [31:0] busAddr, busWrData, loadResult;
  logic [3:0]  wrStrobe;
  logic        alignFault, loadValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ldst_agu u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isStore(isStore), .accSize(accSize),
    .isSigned(isSigned), .addrMode(addrMode), .baseVal(baseVal), .indexVal(indexVal),
    .spVal(spVal), .pcVal(pcVal), .storeData(storeData), .rdValid(rdValid), .rdData(rdData),
    .busAddr(busAddr), .wrStrobe(wrStrobe), .busWrData(busWrData), .alignFault(alignFault),
    .loadResult(loadResult), .loadValid(loadValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // present a request on a falling edge, let combinational outputs settle
  task automatic req(input logic v, input logic st, input logic [1:0] sz, input logic sg,
                     input logic [1:0] md, input logic [31:0] idx);
    @(negedge clk);
    reqValid = v; isStore = st; accSize = sz; isSigned = sg; addrMode = md; indexVal = idx;
    rdValid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R11 reset loadValid", 32'(loadValid), 0);
    chk("R11 reset loadResult", loadResult, 0);
  endtask

  task automatic t_regIndex();
    baseVal = 32'h1000;
    req(1, 0, 2'd0, 0, 2'd0, 32'h22);       chk("R1 byte reg index", busAddr, 32'h1022);
    req(1, 0, 2'd2, 0, 2'd0, 32'h8);        chk("R1 word reg index", busAddr, 32'h1008);
    req(1, 0, 2'd2, 0, 2'd0, 32'hFFFFFFFC); chk("R1 negative index", busAddr, 32'h0FFC);
  endtask

  task automatic t_shortImm();
    baseVal = 32'h1000;
    req(1, 0, 2'd0, 0, 2'd1, 32'h5);        chk("R2 byte imm5", busAddr, 32'h1005);
    req(1, 0, 2'd1, 0, 2'd1, 32'h5);        chk("R2 half imm5", busAddr, 32'h100A);
    req(1, 0, 2'd2, 0, 2'd1, 32'h5);        chk("R2 word imm5", busAddr, 32'h1014);
    req(1, 0, 2'd2, 0, 2'd1, 32'hFFFFFFE5); chk("R2 upper bits ignored", busAddr, 32'h1014);
  endtask

  task automatic t_stackRel();
    spVal = 32'h2000_0100;
    req(1, 0, 2'd2, 0, 2'd2, 32'h1FF);      chk("R3 sp imm8", busAddr, 32'h2000_04FC);
    req(1, 0, 2'd2, 0, 2'd2, 32'h0);        chk("R3 sp zero", busAddr, 32'h2000_0100);
  endtask

  task automatic t_pcRel();
    pcVal = 32'h102;
    req(1, 0, 2'd2, 0, 2'd3, 32'h3);        chk("R4 pc rounded", busAddr, 32'h110);
    pcVal = 32'h0FE;
    req(1, 0, 2'd2, 0, 2'd3, 32'h100);      chk("R4 pc imm8 only", busAddr, 32'h100);
  endtask

  task automatic t_fault();
    baseVal = 32'h1000; storeData = 32'h12345678;
    req(1, 0, 2'd1, 0, 2'd0, 32'h1); chk("R5 half odd", 32'(alignFault), 1);
    req(1, 0, 2'd2, 0, 2'd0, 32'h2); chk("R5 word offset 2", 32'(alignFault), 1);
    req(1, 0, 2'd3, 0, 2'd0, 32'h1); chk("R5 reserved size as word", 32'(alignFault), 1);
    req(1, 0, 2'd0, 0, 2'd0, 32'h3); chk("R5 byte never faults", 32'(alignFault), 0);
    req(1, 0, 2'd1, 0, 2'd0, 32'h2); chk("R5 half aligned", 32'(alignFault), 0);
    req(0, 0, 2'd2, 0, 2'd0, 32'h3); chk("R5 idle no fault", 32'(alignFault), 0);
    req(1, 1, 2'd1, 0, 2'd0, 32'h1); chk("R6 faulting store strobe", 32'(wrStrobe), 0);
    req(1, 0, 2'd2, 0, 2'd0, 32'h2);
    rdData = 32'hDEADBEEF; rdValid = 1'b1;
    @(negedge clk); #1;
    chk("R6 faulting load no valid", 32'(loadValid), 0);
    chk("R6 faulting load result held", loadResult, 0);
  endtask

  task automatic t_store();
    baseVal = 32'h1000; storeData = 32'h12345678;
    req(1, 1, 2'd0, 0, 2'd0, 32'h3);
    chk("R7 byte lane 3 strobe", 32'(wrStrobe), 32'h8);
    chk("R8 byte replicate", busWrData, 32'h78787878);
    req(1, 1, 2'd1, 0, 2'd0, 32'h2);
    chk("R7 upper half strobe", 32'(wrStrobe), 32'hC);
    chk("R8 half replicate", busWrData, 32'h56785678);
    req(1, 1, 2'd1, 0, 2'd0, 32'h0);
    chk("R7 lower half strobe", 32'(wrStrobe), 32'h3);
    req(1, 1, 2'd2, 0, 2'd0, 32'h4);
    chk("R7 word strobe", 32'(wrStrobe), 32'hF);
    chk("R8 word data", busWrData, 32'h12345678);
    req(1, 0, 2'd0, 0, 2'd0, 32'h0);
    chk("R7 load no strobe", 32'(wrStrobe), 0);
    req(0, 1, 2'd2, 0, 2'd0, 32'h0);
    chk("R7 idle no strobe", 32'(wrStrobe), 0);
  endtask

  // one load: request plus read data, result checked after the capturing edge
  task automatic doLoad(input string tag, input logic [1:0] sz, input logic sg,
                        input logic [31:0] idx, input logic [31:0] exp);
    req(1, 0, sz, sg, 2'd0, idx);
    rdData = 32'h8A7B6C5D; rdValid = 1'b1;
    @(negedge clk); #1;
    chk({tag, " valid"}, 32'(loadValid), 1);
    chk(tag, loadResult, exp);
    rdValid = 1'b0;
  endtask

  task automatic t_load();
    baseVal = 32'h1000;
    doLoad("R9 byte lane 2 unsigned", 2'd0, 0, 32'h2, 32'h0000007B);
    doLoad("R10 byte lane 3 signed", 2'd0, 1, 32'h3, 32'hFFFFFF8A);
    doLoad("R10 byte signed positive", 2'd0, 1, 32'h1, 32'h0000006C);
    doLoad("R9 upper half unsigned", 2'd1, 0, 32'h2, 32'h00008A7B);
    doLoad("R10 upper half signed", 2'd1, 1, 32'h2, 32'hFFFF8A7B);
    doLoad("R10 lower half signed positive", 2'd1, 1, 32'h0, 32'h00006C5D);
    doLoad("R10 word ignores sign flag", 2'd2, 1, 32'h4, 32'h8A7B6C5D);
    @(negedge clk); #1;
    chk("R11 pulse drops", 32'(loadValid), 0);
    chk("R11 result held", loadResult, 32'h8A7B6C5D);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    t_reset();
    t_regIndex();
    t_shortImm();
    t_stackRel();
    t_pcRel();
    t_fault();
    t_store();
    t_load();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule